// File: doc/BRIEF.md
# Configurable Bit-Serial Sample Receiver

This block turns a framed, most-significant-bit-first serial stream into samples for one transmit channel. Each sample is either a 16-bit real value or a 16-bit I/Q complex pair. A fast system clock oversamples the serial clock, serial data and frame strobe through two-flop synchronisers. The block picks out the serial clock edge selected by the mode byte. A frame strobe that is active on that edge marks the first bit of a new word.

Flow control follows a pull model. When the block is idle and the downstream side signals ready, it issues a one-cycle request pulse. It then accepts exactly one sample and presents it with a one-cycle valid pulse. A word that arrives while no request is outstanding is discarded and reported on an overrun pulse.

A run-time mode byte selects four things: a packed 32-bit I/Q transfer or separate I and Q words, real or complex samples, the capturing serial clock edge, and the frame strobe polarity. The same byte carries a parallel/serial select bit for this channel; when that bit selects parallel input, the receiver stays idle.

Top module: `serial_sample_rx`

## Requirements
- R1: While reset is high, and on the first sample after it, req_o, valid_o and overrun_o are 0 and both sample outputs are 0.
- R2: With mode bit 1 set (real input), one framed 16-bit word, most significant bit first, forms one sample. It appears on sample_i_o, and sample_q_o is 0. Real input takes precedence over mode bit 0.
- R3: With mode bit 0 set and bit 1 clear (packed pair), one framed 32-bit word forms one sample, with I = bits 31..16 and Q = bits 15..0.
- R4: With mode bits 0 and 1 both clear, the first framed 16-bit word after a request is I and the next framed 16-bit word is Q. valid_o does not pulse after the I word, only after the Q word.
- R5: With mode bit 2 clear, data and frame are captured on rising serial clock edges. With it set, they are captured on falling edges.
- R6: With mode bit 3 clear, the frame strobe is active high. With it set, it is active low.
- R7: An active frame strobe on a capturing edge restarts the word at its first bit. A partially received word is discarded.
- R8: req_o is a one-cycle pulse, raised only when no request is outstanding and ready_i was high on the previous clock edge. It is not raised again until the requested sample has completed.
- R9: A complete word that arrives with no request outstanding is dropped. It produces a one-cycle overrun_o pulse and no valid_o.
- R10: While mode bit 4+CHAN_IDX (bit 4 for the default channel) is 1, the receiver issues no req_o, valid_o or overrun_o. Clearing the bit lets a request follow on the next cycle when ready_i is high.
- R11: valid_o (or overrun_o) is a one-cycle pulse. It is seen in the fourth system cycle after the final capturing serial edge of a sample's last word reaches the input pin. The system clock must run at least four times the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 8 | Mode byte: bit0 packed pair, bit1 real input, bit2 falling-edge capture, bit3 active-low frame, bits 7..4 parallel select per channel |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_frame_i | input | 1 | Frame strobe marking the first bit of a word |
| ready_i | input | 1 | Downstream is ready for another sample |
| req_o | output | 1 | One-cycle request for the next sample |
| valid_o | output | 1 | One-cycle pulse qualifying the sample outputs |
| sample_i_o | output | 16 | Real sample or I component |
| sample_q_o | output | 16 | Q component (0 for real samples) |
| overrun_o | output | 1 | One-cycle pulse when an unrequested word is dropped |

## Verification
The bench changes inputs only at falling system clock edges and samples outputs at falling edges as well. Each result is therefore due a fixed number of cycles after its cause. A request is due at the first falling edge after ready_i rises while idle. A valid or overrun pulse is due at the fourth falling edge after the final capturing serial edge is applied: two synchroniser stages, the word-assembly register and the output register. For every word the bench watches a six-cycle window. It demands the pulse in exactly the fourth slot and nowhere else, so both a lost pulse and a pulse that comes early, late or twice are reported. For the silent cases (the I half of an unpacked pair, ready low, parallel select), the bench watches req_o, valid_o and overrun_o over the same kind of window and expects them to stay low.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    // Mode byte layout; field order gives bit 0 = packed_pair up to bits 7..4 = par_sel.
    typedef struct packed {
        logic [3:0] par_sel;
        logic       fs_low;
        logic       sck_fall;
        logic       real_in;
        logic       packed_pair;
    } mode_t;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_WAIT   = 2'd1,
        RX_WAIT_Q = 2'd2
    } rx_state_t;

    function automatic mode_t decode_mode(input logic [7:0] raw);
        return mode_t'(raw);
    endfunction

    // A full 32-bit transfer is expected only for packed complex pairs.
    function automatic logic wide_word(input mode_t m);
        return m.packed_pair & ~m.real_in;
    endfunction

endpackage

// File: rtl/ssr_front.sv
module ssr_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk_i,
    input  logic ser_data_i,
    input  logic ser_frame_i,
    input  logic fall_sel,
    input  logic fs_low,
    output logic strobe_o,
    output logic bit_o,
    output logic frame_o
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] sdi_q;
    logic [STAGES-1:0] sfs_q;
    logic              sck_prev;
    logic              sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= '0;
            sdi_q    <= '0;
            sfs_q    <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], ser_clk_i};
            sdi_q    <= {sdi_q[STAGES-2:0], ser_data_i};
            sfs_q    <= {sfs_q[STAGES-2:0], ser_frame_i};
            sck_prev <= sck_s;
        end
    end

    always_comb begin
        sck_s    = sck_q[STAGES-1];
        strobe_o = fall_sel ? (sck_prev & ~sck_s) : (~sck_prev & sck_s);
        bit_o    = sdi_q[STAGES-1];
        frame_o  = sfs_q[STAGES-1] ^ fs_low;
    end

endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  wide,
    input  logic                  strobe,
    input  logic                  bit_in,
    input  logic                  frame,
    output logic                  done_o,
    output logic [2*SAMPLE_W-1:0] word_o
);
    localparam int WORD2 = 2 * SAMPLE_W;
    localparam int CNT_W = $clog2(WORD2 + 1);

    logic [WORD2-1:0] sh, sh_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt, target;
    logic             active;
    logic             take;

    always_comb begin
        sh_nxt  = {sh[WORD2-2:0], bit_in};
        cnt_nxt = frame ? CNT_W'(1) : cnt + CNT_W'(1);
        target  = wide ? CNT_W'(WORD2) : CNT_W'(SAMPLE_W);
        take    = strobe && (frame || active);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            sh     <= '0;
            cnt    <= '0;
            active <= 1'b0;
            done_o <= 1'b0;
            word_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (take) begin
                sh <= sh_nxt;
                if (cnt_nxt == target) begin
                    done_o <= 1'b1;
                    word_o <= sh_nxt;
                    active <= 1'b0;
                    cnt    <= '0;
                end else begin
                    active <= 1'b1;
                    cnt    <= cnt_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl import ssr_pkg::*; #(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  real_in,
    input  logic                  packed_pair,
    input  logic                  ready_i,
    input  logic                  done_i,
    input  logic [2*SAMPLE_W-1:0] word_i,
    output logic                  req_o,
    output logic                  valid_o,
    output logic                  overrun_o,
    output logic [SAMPLE_W-1:0]   samp_i_o,
    output logic [SAMPLE_W-1:0]   samp_q_o
);
    rx_state_t           state;
    logic [SAMPLE_W-1:0] stash_i;
    logic [SAMPLE_W-1:0] lo_half, hi_half;

    always_comb begin
        lo_half = word_i[SAMPLE_W-1:0];
        hi_half = word_i[2*SAMPLE_W-1:SAMPLE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            req_o     <= 1'b0;
            valid_o   <= 1'b0;
            overrun_o <= 1'b0;
            samp_i_o  <= '0;
            samp_q_o  <= '0;
            stash_i   <= '0;
        end else begin
            req_o     <= 1'b0;
            valid_o   <= 1'b0;
            overrun_o <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (done_i) begin
                            overrun_o <= 1'b1;
                        end else if (ready_i) begin
                            req_o <= 1'b1;
                            state <= RX_WAIT;
                        end
                    end
                    RX_WAIT: begin
                        if (done_i) begin
                            if (real_in) begin
                                samp_i_o <= lo_half;
                                samp_q_o <= '0;
                                valid_o  <= 1'b1;
                                state    <= RX_IDLE;
                            end else if (packed_pair) begin
                                samp_i_o <= hi_half;
                                samp_q_o <= lo_half;
                                valid_o  <= 1'b1;
                                state    <= RX_IDLE;
                            end else begin
                                stash_i <= lo_half;
                                state   <= RX_WAIT_Q;
                            end
                        end
                    end
                    RX_WAIT_Q: begin
                        if (done_i) begin
                            samp_i_o <= stash_i;
                            samp_q_o <= lo_half;
                            valid_o  <= 1'b1;
                            state    <= RX_IDLE;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_sample_rx.sv
module serial_sample_rx import ssr_pkg::*; #(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CHAN_IDX    = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          mode_i,
    input  logic                ser_clk_i,
    input  logic                ser_data_i,
    input  logic                ser_frame_i,
    input  logic                ready_i,
    output logic                req_o,
    output logic                valid_o,
    output logic [SAMPLE_W-1:0] sample_i_o,
    output logic [SAMPLE_W-1:0] sample_q_o,
    output logic                overrun_o
);
    mode_t                 mode;
    logic                  serial_en;
    logic                  strobe, bit_s, frame_s;
    logic                  done;
    logic [2*SAMPLE_W-1:0] word;

    always_comb begin
        mode      = decode_mode(mode_i);
        serial_en = ~mode.par_sel[CHAN_IDX];
    end

    ssr_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk         (clk),
        .rst         (rst),
        .ser_clk_i   (ser_clk_i),
        .ser_data_i  (ser_data_i),
        .ser_frame_i (ser_frame_i),
        .fall_sel    (mode.sck_fall),
        .fs_low      (mode.fs_low),
        .strobe_o    (strobe),
        .bit_o       (bit_s),
        .frame_o     (frame_s)
    );

    ssr_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .enable (serial_en),
        .wide   (wide_word(mode)),
        .strobe (strobe),
        .bit_in (bit_s),
        .frame  (frame_s),
        .done_o (done),
        .word_o (word)
    );

    ssr_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .enable      (serial_en),
        .real_in     (mode.real_in),
        .packed_pair (mode.packed_pair),
        .ready_i     (ready_i),
        .done_i      (done),
        .word_i      (word),
        .req_o       (req_o),
        .valid_o     (valid_o),
        .overrun_o   (overrun_o),
        .samp_i_o    (sample_i_o),
        .samp_q_o    (sample_q_o)
    );

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
    parameter int CHAN_IDX = 0
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] mode_i,
    input logic       ready_i,
    input logic       req_o,
    input logic       valid_o,
    input logic       overrun_o
);
    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    assert_req_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(ready_i));

    assert_no_req_parallel_R10: assert property (@(posedge clk) disable iff (rst)
        req_o |-> !$past(mode_i[4+CHAN_IDX]));

    assert_no_valid_parallel_R10: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !$past(mode_i[4+CHAN_IDX]));

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_overrun_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> !overrun_o);

    assert_overrun_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && overrun_o));

endmodule

bind serial_sample_rx ssr_checker #(.CHAN_IDX(CHAN_IDX)) u_ssr_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .ready_i   (ready_i),
    .req_o     (req_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o)
);

// File: tb/tb_serial_sample_rx.sv
module tb_serial_sample_rx;

    localparam int HALF  = 4;
    localparam int NVEC  = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  mode_i;
    logic        ser_clk_i, ser_data_i, ser_frame_i, ready_i;
    logic        req_o, valid_o, overrun_o;
    logic [15:0] sample_i_o, sample_q_o;

    int n_chk = 0;
    int n_err = 0;

    // {mode[39:32], I[31:16], Q[15:0]}
    localparam logic [39:0] VECS [NVEC] = '{
        {8'h02, 16'hA5C3, 16'h0000},   // R2 real, rising edge, high frame
        {8'h01, 16'h1234, 16'hABCD},   // R3 packed pair
        {8'h00, 16'h8001, 16'h7FFE},   // R4 separate I then Q
        {8'h06, 16'hF00F, 16'h0000},   // R5 real, falling edge
        {8'h09, 16'h0F0F, 16'hC3A5},   // R6 packed, active-low frame
        {8'h0C, 16'h5555, 16'hAAAA}    // R5/R6 separate, falling, low frame
    };

    serial_sample_rx dut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_frame_i(ser_frame_i),
        .ready_i(ready_i), .req_o(req_o), .valid_o(valid_o),
        .sample_i_o(sample_i_o), .sample_q_o(sample_q_o), .overrun_o(overrun_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a falling system edge; returns at the one where the
    // last capturing serial edge has been applied.
    task automatic send_word(input logic [31:0] w, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            ser_clk_i   = mode_i[2];
            ser_data_i  = w[b];
            ser_frame_i = (b == n - 1) ? ~mode_i[3] : mode_i[3];
            repeat (HALF) @(negedge clk);
            ser_clk_i = ~mode_i[2];
            if (b > 0) repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic observe(output int v_at, output int o_at, output int v_n, output int o_n,
                           output logic [15:0] ci, output logic [15:0] cq);
        v_at = 0; o_at = 0; v_n = 0; o_n = 0; ci = '0; cq = '0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (valid_o) begin
                v_n++;
                if (v_at == 0) v_at = k;
                ci = sample_i_o;
                cq = sample_q_o;
            end
            if (overrun_o) begin
                o_n++;
                if (o_at == 0) o_at = k;
            end
        end
    endtask

    task automatic count_req(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (req_o) cnt++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int va, oa, vn, on, rc;
        logic [15:0] ci, cq;
        logic [39:0] v;

        rst = 1'b1; mode_i = 8'h00; ready_i = 1'b0;
        ser_clk_i = 1'b0; ser_data_i = 1'b0; ser_frame_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset outputs", {req_o, valid_o, overrun_o, sample_i_o[0], sample_q_o[0]}, 0);
        chk("R1 reset sample", {sample_i_o, sample_q_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle after reset", {req_o, valid_o, overrun_o}, 0);

        // R8: no request while ready is low
        count_req(10, rc);
        chk("R8 no req without ready", rc, 0);
        ready_i = 1'b1;
        @(negedge clk);
        chk("R8 req one cycle after ready", req_o, 1);
        count_req(10, rc);
        chk("R8 single req while outstanding", rc, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            mode_i = v[39:32];
            repeat (2) @(negedge clk);
            if (mode_i[1]) begin
                send_word({16'h0, v[31:16]}, 16);
            end else if (mode_i[0]) begin
                send_word(v[31:0], 32);
            end else begin
                send_word({16'h0, v[31:16]}, 16);
                observe(va, oa, vn, on, ci, cq);
                chk($sformatf("R4 no valid after I word vec%0d", i), vn, 0);
                send_word({16'h0, v[15:0]}, 16);
            end
            observe(va, oa, vn, on, ci, cq);
            chk($sformatf("R11 valid latency vec%0d", i), va, 4);
            chk($sformatf("R11 single valid vec%0d", i), vn, 1);
            chk($sformatf("R2 R3 R4 R5 R6 sample vec%0d", i), {ci, cq}, v[31:0]);
        end

        // R9: overrun. Satisfy the outstanding request with ready low first.
        ready_i = 1'b0;
        mode_i  = 8'h02;
        repeat (2) @(negedge clk);
        send_word(32'h0000_1111, 16);
        observe(va, oa, vn, on, ci, cq);
        chk("R2 real word before overrun", {vn, 16'h0, ci}, {32'd1, 16'h0, 16'h1111});
        count_req(4, rc);
        chk("R8 no req with ready low", rc, 0);
        send_word(32'h0000_2222, 16);
        observe(va, oa, vn, on, ci, cq);
        chk("R9 overrun latency", oa, 4);
        chk("R9 overrun single pulse", on, 1);
        chk("R9 no valid on dropped word", vn, 0);

        // R7: frame restart discards a partial word
        ready_i = 1'b1;
        @(negedge clk);
        chk("R8 req after ready returns", req_o, 1);
        send_word(32'h0000_007F, 7);
        send_word(32'h0000_3C5A, 16);
        observe(va, oa, vn, on, ci, cq);
        chk("R7 restart latency", va, 4);
        chk("R7 partial word discarded", ci, 16'h3C5A);

        // R10: parallel select holds the receiver idle (bit 4 for channel 0)
        mode_i = 8'h12;
        count_req(12, rc);
        chk("R10 no req in parallel", rc, 0);
        send_word(32'h0000_4444, 16);
        observe(va, oa, vn, on, ci, cq);
        chk("R10 no valid or overrun in parallel", {vn[15:0], on[15:0]}, 0);
        mode_i = 8'h02;
        @(negedge clk);
        chk("R10 req after serial restored", req_o, 1);
        send_word(32'h0000_BEEF, 16);
        observe(va, oa, vn, on, ci, cq);
        chk("R10 sample after serial restored", {va[15:0], ci}, {16'd4, 16'hBEEF});

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule